// File: doc/BRIEF.md
# Gated Retriggerable Digital Monostable

This block is a clock-synchronous one-shot. A trigger produces a pulse on `q`, and `q_n` is its complement. The pulse length is a cycle count taken from the `width` input at the moment the pulse starts, so no resistor-capacitor network sets the timing. Edges are found by comparing each input with its value on the previous clock. The inputs must already be synchronous to `clk`.

There are two trigger inputs, each gated by the other:
- `trig_a_n` is an active-low trigger. Its falling edge fires only while `trig_b` is high.
- `trig_b` is an active-high trigger. Its rising edge fires only while `trig_a_n` is low.

The other controls are:
- An active-low clear, `clr_n`. It ends a pulse at once, and it can optionally start one on its release.
- A two-bit mask, `edge_mask`, that suppresses negative-going triggers, positive-going triggers, or both.
- A mode input, `retrig_en`, that picks between restarting the interval on a new trigger and ignoring triggers while a pulse runs.

All controls are plain level pins. There is no data stream, so there is no handshake. The block typically sits in pulse stretching, timeout watchdogs, missing-edge detection and envelope detection, where a burst of edges must hold one output level.

Top module: `gated_oneshot`

## Requirements
- R1: A falling edge of `trig_a_n` that happens while `trig_b` = 1 and `clr_n` = 1 starts a pulse. `q` goes high after the sampling clock edge and stays high for exactly `width` cycles.
- R2: A rising edge of `trig_b` that happens while `trig_a_n` = 0 and `clr_n` = 1 starts a pulse of `width` cycles.
- R3: While `clr_n` = 0, `q` = 0 and `q_n` = 1 without waiting for a clock edge. Any running pulse is cancelled and does not resume when `clr_n` returns high.
- R4: While `trig_a_n` = 1, a rising edge of `trig_b` starts nothing. While `trig_b` = 0, a falling edge of `trig_a_n` starts nothing. A rising edge of `trig_a_n` never triggers.
- R5: With `retrig_en` = 1, a qualifying edge during a pulse reloads the full `width`. The total high time is then the cycles already elapsed plus `width`.
- R6: With `retrig_en` = 0, qualifying edges during a pulse are ignored and the pulse ends on its original schedule.
- R7: With `clr_trig_en` = 1, a rising edge of `clr_n` while `trig_a_n` = 0 and `trig_b` = 1 starts a pulse. With `clr_trig_en` = 0, releasing clear never starts one. A release while `trig_a_n` = 1 never starts one.
- R8: `edge_mask` bit 0 = 1 blocks negative-going triggers (the falling edge of `trig_a_n`). Bit 1 = 1 blocks positive-going triggers (the rising edges of `trig_b` and of `clr_n`). 00 allows both, and 11 allows none.
- R9: `width` is captured when a pulse starts, so later changes do not alter it. A trigger that arrives while `width` = 0 has no effect.
- R10: When `clr_n` is low in the same cycle as an otherwise qualifying edge, clear wins and no pulse is produced.
- R11: After reset `q` = 0 and `q_n` = 1, and input levels held through the reset release do not count as edges. `q_n` is always the complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a_n | input | 1 | Active-low trigger; its falling edge fires while `trig_b` is high |
| trig_b | input | 1 | Active-high trigger; its rising edge fires while `trig_a_n` is low |
| clr_n | input | 1 | Active-low clear; its release may trigger when enabled |
| clr_trig_en | input | 1 | 1 lets a rising edge of `clr_n` start a pulse |
| retrig_en | input | 1 | 1 selects retriggerable mode, 0 selects non-retriggerable mode |
| edge_mask | input | 2 | Bit 0 blocks negative-going triggers; bit 1 blocks positive-going triggers |
| width | input | CNT_W | Pulse length in clock cycles, captured on a trigger |
| q | output | 1 | Pulse output, high while timing |
| q_n | output | 1 | Complement of `q` |

## Verification
Clear and a trigger can fall in the same cycle. Clear can also land while a retriggerable pulse is in flight, which competes with the reload path. The bench drives `clr_n` low in the very cycle that `trig_a_n` falls with `trig_b` high, and then releases clear with the clear-trigger option off. It judges the outcome by `q` staying low both in the sampled cycle and after the release. It also pulls clear in the middle of a long pulse and checks `q` immediately, without waiting for an edge, and again over the following cycles.

// File: rtl/oneshot_pkg.sv
`timescale 1ns/1ps
package oneshot_pkg;
  // positions inside the edge_mask field
  localparam int MASK_NEG_BIT = 0;
  localparam int MASK_POS_BIT = 1;

  // qualified trigger requests of one cycle
  typedef struct packed {
    logic neg_go;  // falling edge of the active-low trigger
    logic pos_go;  // rising edge of the active-high trigger or of clear
  } trig_req_t;
endpackage

// File: rtl/oneshot_trig_qual.sv
`timescale 1ns/1ps
module oneshot_trig_qual
  import oneshot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_n,
  input  logic       b,
  input  logic       clr_n,
  input  logic       clr_trig_en,
  input  logic [1:0] edge_mask,
  output trig_req_t  req
);
  // previous samples; reset values chosen so that no edge is seen on the first cycle
  logic a_prev, b_prev, c_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev <= 1'b0;
      b_prev <= 1'b1;
      c_prev <= 1'b1;
    end else begin
      a_prev <= a_n;
      b_prev <= b;
      c_prev <= clr_n;
    end
  end

  logic a_fell, b_rose, c_rose;
  assign a_fell = a_prev & ~a_n;
  assign b_rose = ~b_prev & b;
  assign c_rose = ~c_prev & clr_n;

  always_comb begin
    req.neg_go = a_fell & b & clr_n & ~edge_mask[MASK_NEG_BIT];
    req.pos_go = ((b_rose & ~a_n) | (clr_trig_en & c_rose & ~a_n & b))
               & clr_n & ~edge_mask[MASK_POS_BIT];
  end
endmodule

// File: rtl/oneshot_timer.sv
`timescale 1ns/1ps
module oneshot_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             fire,
  input  logic             retrig_en,
  input  logic [CNT_W-1:0] width,
  output logic             active
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] remain;
  logic             load;

  assign load   = fire && (width != ZERO) && (retrig_en || (remain == ZERO));
  assign active = (remain != ZERO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= ZERO;
    else if (!clr_n)          remain <= ZERO;
    else if (load)            remain <= width;
    else if (remain != ZERO)  remain <= remain - 1'b1;
  end
endmodule

// File: rtl/gated_oneshot.sv
`timescale 1ns/1ps
module gated_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic             clr_n,
  input  logic             clr_trig_en,
  input  logic             retrig_en,
  input  logic [1:0]       edge_mask,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             q_n
);
  trig_req_t req;
  logic      running;

  oneshot_trig_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_n         (trig_a_n),
    .b           (trig_b),
    .clr_n       (clr_n),
    .clr_trig_en (clr_trig_en),
    .edge_mask   (edge_mask),
    .req         (req)
  );

  oneshot_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .fire      (req.neg_go | req.pos_go),
    .retrig_en (retrig_en),
    .width     (width),
    .active    (running)
  );

  // clear forces idle without waiting for an edge
  assign q   = running & clr_n;
  assign q_n = ~q;
endmodule

// File: rtl/gated_oneshot_chk.sv
`timescale 1ns/1ps
module gated_oneshot_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_a_n,
  input logic             trig_b,
  input logic             clr_n,
  input logic [1:0]       edge_mask,
  input logic [CNT_W-1:0] width,
  input logic             q
);
  logic [1:0] age;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age <= 2'd0;
    else if (age != 2'd3)  age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  // R3
  clr_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !q);

  // R10
  rose_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(q)) |-> $past(clr_n));

  // R9
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(q)) |-> ($past(width) != '0));

  // R8
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(q)) |-> ($past(edge_mask) != 2'b11));

  // R4
  rose_has_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(q)) |->
      (($past(trig_a_n, 2) && !$past(trig_a_n)) ||
       (!$past(trig_b, 2) && $past(trig_b)) ||
       (!$past(clr_n, 2) && $past(clr_n))));
endmodule

bind gated_oneshot gated_oneshot_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_a_n  (trig_a_n),
  .trig_b    (trig_b),
  .clr_n     (clr_n),
  .edge_mask (edge_mask),
  .width     (width),
  .q         (q)
);

// File: tb/gated_oneshot_bench.sv
`timescale 1ns/1ps
module gated_oneshot_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trig_a_n = 1'b1;
  logic             trig_b = 1'b1;
  logic             clr_n = 1'b1;
  logic             clr_trig_en = 1'b0;
  logic             retrig_en = 1'b0;
  logic [1:0]       edge_mask = 2'b00;
  logic [CNT_W-1:0] width = 8'd5;
  logic             q, q_n;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  gated_oneshot #(.CNT_W(CNT_W)) u_gated_oneshot (
    .clk(clk), .rst_n(rst_n), .trig_a_n(trig_a_n), .trig_b(trig_b),
    .clr_n(clr_n), .clr_trig_en(clr_trig_en), .retrig_en(retrig_en),
    .edge_mask(edge_mask), .width(width), .q(q), .q_n(q_n)
  );

  // driver: push the expected output for the sample after the coming edge
  task automatic cyc(input bit e, input string t);
    @(posedge clk);
    #2;
    exp_q.push_back(e);
    tag_q.push_back(t);
    #3;
  endtask

  task automatic run(input bit e, input int n, input string t);
    for (int i = 0; i < n; i++) cyc(e, t);
  endtask

  task automatic now_chk(input bit e, input string t);
    #1;
    total++;
    if (q !== e || q_n !== ~e) begin
      bad++;
      $display("FAIL %s: q=%b q_n=%b expected q=%b", t, q, q_n, e);
    end
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        total++;
        if (q !== e || q_n !== ~e) begin
          bad++;
          $display("FAIL %s: q=%b q_n=%b expected q=%b", t, q, q_n, e);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    now_chk(1'b0, "R11 reset");
    rst_n = 1'b1;
    run(1'b0, 2, "R11 idle after reset");

    // R1: A falls with B high
    width = 8'd5; trig_a_n = 1'b0;
    run(1'b1, 5, "R1 pulse");
    run(1'b0, 2, "R1 end");
    trig_a_n = 1'b1;
    cyc(1'b0, "R4 A rising");

    // R2: B rises with A low; A falling while B low is blocked (R4)
    width = 8'd3; trig_b = 1'b0;
    cyc(1'b0, "R4 B low");
    trig_a_n = 1'b0;
    cyc(1'b0, "R4 A fall with B low");
    trig_b = 1'b1;
    run(1'b1, 3, "R2 pulse");
    cyc(1'b0, "R2 end");
    trig_a_n = 1'b1;
    cyc(1'b0, "R2 idle");

    // R4: B rises while A high
    trig_b = 1'b0;
    cyc(1'b0, "R4");
    trig_b = 1'b1;
    run(1'b0, 2, "R4 B rise with A high");

    // R9: width captured at trigger, later change ignored
    width = 8'd4; trig_a_n = 1'b0;
    cyc(1'b1, "R9");
    width = 8'd9;
    run(1'b1, 3, "R9 captured width");
    cyc(1'b0, "R9 end");
    trig_a_n = 1'b1; width = 8'd0;
    cyc(1'b0, "R9");
    trig_a_n = 1'b0;
    run(1'b0, 3, "R9 zero width");
    trig_a_n = 1'b1; width = 8'd4;
    cyc(1'b0, "R9");

    // R5: retrigger after 3 cycles -> 3 + 4 high
    retrig_en = 1'b1; trig_a_n = 1'b0;
    cyc(1'b1, "R5");
    cyc(1'b1, "R5");
    trig_b = 1'b0;
    cyc(1'b1, "R5");
    trig_b = 1'b1;
    cyc(1'b1, "R5 reload");
    run(1'b1, 3, "R5 extended");
    cyc(1'b0, "R5 end");
    trig_a_n = 1'b1;
    cyc(1'b0, "R5");

    // R6: same stimulus, retrigger ignored
    retrig_en = 1'b0; trig_a_n = 1'b0;
    cyc(1'b1, "R6");
    cyc(1'b1, "R6");
    trig_b = 1'b0;
    cyc(1'b1, "R6");
    trig_b = 1'b1;
    cyc(1'b1, "R6 ignored edge");
    run(1'b0, 2, "R6 original end");
    trig_a_n = 1'b1;
    cyc(1'b0, "R6");

    // R3: clear mid-pulse, immediate and lasting
    width = 8'd10; trig_a_n = 1'b0;
    run(1'b1, 3, "R3 before clear");
    clr_n = 1'b0;
    now_chk(1'b0, "R3 immediate");
    run(1'b0, 2, "R3 held");
    clr_n = 1'b1;
    run(1'b0, 3, "R7 release without option");
    trig_a_n = 1'b1;
    cyc(1'b0, "R3");

    // R7: clear release triggers when enabled
    clr_trig_en = 1'b1; width = 8'd3; clr_n = 1'b0;
    cyc(1'b0, "R3");
    trig_a_n = 1'b0;
    cyc(1'b0, "R3 fall under clear");
    clr_n = 1'b1;
    run(1'b1, 3, "R7 clear trigger");
    cyc(1'b0, "R7 end");
    trig_a_n = 1'b1; clr_n = 1'b0;
    cyc(1'b0, "R7");
    clr_n = 1'b1;
    run(1'b0, 2, "R7 release with A high");
    clr_trig_en = 1'b0;

    // R10: clear and A fall in the same cycle
    width = 8'd5; clr_n = 1'b0; trig_a_n = 1'b0;
    cyc(1'b0, "R10 same cycle");
    clr_n = 1'b1;
    run(1'b0, 2, "R10 after release");
    trig_a_n = 1'b1;
    cyc(1'b0, "R10");

    // R8: edge mask
    width = 8'd2; edge_mask = 2'b01; trig_a_n = 1'b0;
    run(1'b0, 2, "R8 mask 01 blocks A fall");
    trig_b = 1'b0;
    cyc(1'b0, "R8");
    trig_b = 1'b1;
    run(1'b1, 2, "R8 mask 01 B rise");
    cyc(1'b0, "R8");
    trig_a_n = 1'b1;
    cyc(1'b0, "R8");
    edge_mask = 2'b10; trig_b = 1'b0;
    cyc(1'b0, "R8");
    trig_a_n = 1'b0;
    cyc(1'b0, "R8");
    trig_b = 1'b1;
    run(1'b0, 2, "R8 mask 10 blocks B rise");
    trig_a_n = 1'b1;
    cyc(1'b0, "R8");
    trig_a_n = 1'b0;
    run(1'b1, 2, "R8 mask 10 A fall");
    cyc(1'b0, "R8");
    trig_a_n = 1'b1;
    cyc(1'b0, "R8");
    edge_mask = 2'b11; trig_a_n = 1'b0;
    run(1'b0, 2, "R8 mask 11 A fall");
    trig_b = 1'b0;
    cyc(1'b0, "R8");
    trig_b = 1'b1;
    run(1'b0, 2, "R8 mask 11 B rise");
    trig_a_n = 1'b1; edge_mask = 2'b00;
    cyc(1'b0, "R11");

    repeat (2) @(posedge clk);
    #6;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule